// File: doc/BRIEF.md
# Serial Video Scrambler and NRZI Line Codec

This block turns 10-bit parallel video words into a serial line stream with one line bit per clock, so the clock runs at ten times the word rate. Each word goes out most significant bit first. Every data bit passes through a self-synchronizing scrambler with the polynomial x^9 + x^4 + 1. The scrambled bit then drives a toggle register (x + 1), which gives an NRZI line code. The combined generator is (x^9 + x^4 + 1)(x + 1). With NRZI, information sits in transitions and not in levels, so the link works the same with the line inverted.

A matching receive path reverses both steps in the opposite order. It first NRZI-decodes the line by comparing each bit with the one before it. It then descrambles with a feed-forward filter that needs no shared state with the transmitter. Word boundaries on the receive side come from an external strobe that marks the cycle carrying a word's last bit. The receiver marks a word valid only after its history has filled, which happens ten line bits after reset.

Top module: `sdi_codec`

## Requirements
- R1: A word presented with `tx_word_stb` high in cycle t0 is sent most significant bit first. Bit k (k = 0 is bit 9 of the word) sets the line state seen on `ser_out` during cycle t0+k+1.
- R2: The scrambled bit is sc[n] = d[n] XOR sc[n-4] XOR sc[n-9]. The scrambler history is all zeros after reset.
- R3: The line toggles when and only when the scrambled bit is 1: ser_out[n+1] = ser_out[n] XOR sc[n]. `ser_out` is 0 after reset.
- R4: `tx_word_stb` pulses at most once in any 10 cycles. A cycle that carries no word bit feeds a 0 data bit into the scrambler.
- R5: `rx_word_stb` is high in the cycle whose `ser_in` bit is the last bit (bit 0) of a word. The decoded word appears on `rx_word`, with `rx_valid` high, in the next cycle. End to end this is 11 cycles after the word's `tx_word_stb`.
- R6: `rx_valid` stays low for a word unless every one of its ten bits came at least ten line bits after reset. The first word sent after reset is therefore never flagged valid.
- R7: An inverted line (`ser_in` = NOT `ser_out`) from reset onward decodes to the same words.
- R8: `rx_valid` is a one-cycle pulse. `rx_word` changes only in a cycle where `rx_valid` is high.
- R9: When only zero words follow reset, `ser_out` stays low.
- R10: After the line polarity flips at a word boundary, only the word that starts at the flip is corrupted. Every later word decodes correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock (ten times the word rate) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_word_stb | input | 1 | Loads `tx_word` for transmission this cycle |
| tx_word | input | 10 | Parallel word to send |
| ser_out | output | 1 | NRZI-coded scrambled line |
| ser_in | input | 1 | Received line, either polarity |
| rx_word_stb | input | 1 | Marks the cycle carrying a word's last bit |
| rx_word | output | 10 | Recovered word |
| rx_valid | output | 1 | One-cycle pulse: `rx_word` holds a new, fully synchronized word |

## Verification
The assertions assume that transmit strobes are at least ten cycles apart and that the receive strobe keeps the framing of the transmitted words. The bench meets both assumptions by making the receive strobe a ten-cycle delayed copy of the transmit strobe. It issues words back to back or with idle gaps, never closer. Polarity changes happen only at word boundaries, so the one corrupted word is known in advance and is excluded from comparison.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  // Line code geometry
  parameter int SDI_WORD_W = 10;  // bits per parallel word
  parameter int SDI_TAP_LO = 4;   // short scrambler tap (x^4)
  parameter int SDI_TAP_HI = 9;   // long scrambler tap (x^9), also history depth

  // feedback of a self-synchronizing scrambler over a history vector,
  // newest bit in position 0
  function automatic logic scr_feedback(input logic [SDI_TAP_HI-1:0] hist);
    return hist[SDI_TAP_LO-1] ^ hist[SDI_TAP_HI-1];
  endfunction
endpackage

// File: rtl/sdi_rst_sync.sv
module sdi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sdi_tx.sv
module sdi_tx
  import sdi_pkg::*;
#(
  parameter int W   = SDI_WORD_W,
  parameter int TLO = SDI_TAP_LO,
  parameter int THI = SDI_TAP_HI
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_stb,
  input  logic [W-1:0] word,
  output logic         line
);
  localparam int CW = $clog2(W);

  logic [W-1:0]   sh_q, sh_d;
  logic [CW-1:0]  left_q, left_d;
  logic [THI-1:0] st_q, st_d;
  logic           nz_q, nz_d;
  logic           run_q;
  logic           dbit, sbit;

  // next state: serializer, scrambler, toggle stage
  always_comb begin
    dbit   = word_stb ? word[W-1] : sh_q[W-1];
    sh_d   = word_stb ? {word[W-2:0], 1'b0} : {sh_q[W-2:0], 1'b0};
    if (word_stb)           left_d = CW'(W-1);
    else if (left_q != '0)  left_d = left_q - CW'(1);
    else                    left_d = left_q;
    sbit   = dbit ^ st_q[TLO-1] ^ st_q[THI-1];
    st_d   = {st_q[THI-2:0], sbit};
    nz_d   = nz_q ^ sbit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      st_q   <= '0;
      nz_q   <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      st_q   <= st_d;
      nz_q   <= nz_d;
      run_q  <= 1'b1;
    end
  end

  assign line = nz_q;

  // line toggles exactly when the previous scrambled bit was one
  AST_NRZI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ((nz_q != $past(nz_q)) == $past(sbit)));  // R3
  // scrambler history shifts in the scrambled stream
  AST_SCR_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (st_q[0] == (nz_q ^ $past(nz_q))));  // R2
  // a new word never interrupts the previous one
  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> (left_q == '0));  // R4
endmodule

// File: rtl/sdi_rx.sv
module sdi_rx
  import sdi_pkg::*;
#(
  parameter int W   = SDI_WORD_W,
  parameter int TLO = SDI_TAP_LO,
  parameter int THI = SDI_TAP_HI
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         line,
  input  logic         word_stb,
  output logic [W-1:0] word,
  output logic         valid
);
  localparam int LIM  = 2*W - 1;          // bits preceding a word's last bit when fully synced
  localparam int CNTW = $clog2(LIM + 1);

  logic           prev_q;
  logic [THI-1:0] hist_q, hist_d;
  logic [W-2:0]   sh_q, sh_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [W-1:0]   word_q, word_d;
  logic           valid_q, valid_d;
  logic           run_q;
  logic           sbit, dbit, synced, take;

  // next state: NRZI decode, descramble, deserialize
  always_comb begin
    sbit    = line ^ prev_q;
    dbit    = sbit ^ scr_feedback(hist_q);
    hist_d  = {hist_q[THI-2:0], sbit};
    sh_d    = {sh_q[W-3:0], dbit};
    synced  = (cnt_q == CNTW'(LIM));
    cnt_d   = synced ? cnt_q : cnt_q + CNTW'(1);
    take    = word_stb && synced;
    word_d  = take ? {sh_q, dbit} : word_q;
    valid_d = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      hist_q  <= '0;
      sh_q    <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      prev_q  <= line;
      hist_q  <= hist_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      word_q  <= word_d;
      valid_q <= valid_d;
      run_q   <= 1'b1;
    end
  end

  assign word  = word_q;
  assign valid = valid_q;

  AST_VALID_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(word_stb));  // R5
  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(cnt_q) == CNTW'(LIM)));  // R6
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !valid_q) |-> $stable(word_q));  // R8
endmodule

// File: rtl/sdi_codec.sv
module sdi_codec
  import sdi_pkg::*;
#(
  parameter int WORD_W = SDI_WORD_W,
  parameter int TAP_LO = SDI_TAP_LO,
  parameter int TAP_HI = SDI_TAP_HI
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_word_stb,
  input  logic [WORD_W-1:0] tx_word,
  output logic              ser_out,
  input  logic              ser_in,
  input  logic              rx_word_stb,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid
);
  logic rst_n_int;

  sdi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sdi_tx #(.W(WORD_W), .TLO(TAP_LO), .THI(TAP_HI)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .word_stb (tx_word_stb),
    .word     (tx_word),
    .line     (ser_out)
  );

  sdi_rx #(.W(WORD_W), .TLO(TAP_LO), .THI(TAP_HI)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .line     (ser_in),
    .word_stb (rx_word_stb),
    .word     (rx_word),
    .valid    (rx_valid)
  );

  // a valid pulse never lasts two cycles while strobes keep their spacing
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n_int)
    rx_valid |=> !rx_valid);  // R8
endmodule

// File: tb/tb_sdi_codec.sv
module tb_sdi_codec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_word_stb = 1'b0;
  logic [9:0] tx_word = '0;
  logic       ser_out;
  logic       ser_in;
  logic       rx_word_stb;
  logic [9:0] rx_word;
  logic       rx_valid;
  logic       inv = 1'b0;
  logic [9:0] stb_hist = '0;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 0;

  // scoreboard
  logic [9:0] q_w[$];
  int         q_c[$];
  bit         q_care[$];
  string      q_tag[$];

  // line model from the code equations
  logic [8:0] m_st = '0;
  logic       m_nz = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) begin
    cyc <= cyc + 1;
    stb_hist <= {stb_hist[8:0], tx_word_stb};
  end
  assign rx_word_stb = stb_hist[9];
  assign ser_in = ser_out ^ inv;

  sdi_codec dut (
    .clk(clk), .rst_n(rst_n), .tx_word_stb(tx_word_stb), .tx_word(tx_word),
    .ser_out(ser_out), .ser_in(ser_in), .rx_word_stb(rx_word_stb),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_bit(input logic d);
    logic sc;
    sc   = d ^ m_st[3] ^ m_st[8];
    m_st = {m_st[7:0], sc};
    m_nz = m_nz ^ sc;
  endfunction

  // starts and ends just after a falling edge
  task automatic send(input logic [9:0] w, input bit push, input bit care,
                      input bit flip, input string tag);
    int bad = 0;
    int first_act = 0, first_exp = 0;
    tx_word_stb = 1'b1;
    tx_word     = w;
    if (push) begin
      q_w.push_back(w); q_c.push_back(cyc); q_care.push_back(care); q_tag.push_back(tag);
    end
    for (int k = 0; k < 10; k++) begin
      model_bit(w[9-k]);
      @(negedge clk);
      if (k == 0) begin
        tx_word_stb = 1'b0;
        if (flip) inv = ~inv;
      end
      if (ser_out !== m_nz) begin
        if (bad == 0) begin first_act = ser_out; first_exp = m_nz; end
        bad++;
      end
    end
    check(bad == 0, "R1/R2/R3", "line bit", first_act, first_exp);
  endtask

  task automatic idle(input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) begin
      model_bit(1'b0);
      @(negedge clk);
      if (ser_out !== m_nz) bad++;
    end
    check(bad == 0, "R4", "idle line bits wrong", bad, 0);
  endtask

  task automatic do_reset(input logic pol);
    @(negedge clk);
    rst_n = 1'b0;
    inv   = pol;
    m_st  = '0;
    m_nz  = 1'b0;
    repeat (2) @(negedge clk);
    check(ser_out === 1'b0, "R3", "reset ser_out", ser_out, 0);
    check(rx_valid === 1'b0, "R6", "reset rx_valid", rx_valid, 0);
    check(rx_word === 10'h000, "R8", "reset rx_word", rx_word, 0);
    rst_n = 1'b1;
    idle(3);
  endtask

  // monitor
  logic       prev_valid = 1'b0;
  logic [9:0] prev_word = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (q_w.size() == 0) begin
          check(0, "R6", "valid word with nothing expected", rx_word, 0);
        end else begin
          logic [9:0] ew;
          int ec;
          bit cr;
          string tg;
          ew = q_w.pop_front(); ec = q_c.pop_front();
          cr = q_care.pop_front(); tg = q_tag.pop_front();
          if (cr) check(rx_word === ew, tg, "word", rx_word, ew);
          check(cyc == ec + 11, "R5", "latency", cyc - ec, 11);
        end
        if (prev_valid) check(0, "R8", "valid longer than one cycle", 2, 1);
      end else if (rx_word !== prev_word) begin
        check(0, "R8", "word changed without valid", rx_word, prev_word);
      end
    end
    prev_valid = rx_valid;
    prev_word  = rx_word;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0] rw;
    do_reset(1'b0);
    // R6: first word after reset is never flagged; R9: zeros keep the line low
    send(10'h000, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) send(10'h000, 1, 1, 0, "R9");
    check(ser_out === 1'b0, "R9", "line after zero words", ser_out, 0);
    // boundary words
    send(10'h3FF, 1, 1, 0, "R1");
    send(10'h200, 1, 1, 0, "R1");
    send(10'h001, 1, 1, 0, "R2");
    send(10'h2AA, 1, 1, 0, "R3");
    // random words
    for (int i = 0; i < 30; i++) begin
      rw = 10'($urandom);
      send(rw, 1, 1, 0, "R5");
    end
    // gaps between words
    idle(7);
    for (int i = 0; i < 5; i++) begin
      rw = 10'($urandom);
      send(rw, 1, 1, 0, "R4");
      idle(3 + i);
    end
    // polarity flip mid-stream: one word lost, then recovery
    send(10'h155, 1, 0, 1, "R10");
    for (int i = 0; i < 12; i++) begin
      rw = 10'($urandom);
      send(rw, 1, 1, 0, "R10");
    end
    idle(15);
    check(q_w.size() == 0, "R5", "words left undelivered", q_w.size(), 0);
    // inverted line from reset
    do_reset(1'b1);
    send(10'h3C3, 0, 0, 0, "R6");
    send(10'h3FF, 1, 1, 0, "R7");
    send(10'h000, 1, 1, 0, "R7");
    for (int i = 0; i < 20; i++) begin
      rw = 10'($urandom);
      send(rw, 1, 1, 0, "R7");
    end
    idle(15);
    check(q_w.size() == 0, "R7", "words left undelivered", q_w.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule